// File: doc/BRIEF.md
# SMBus Host Write-Protect Address Filter

This block sits between the command engine of an SMBus host and its bus transmitter. Before the host opens a transaction, the engine presents the 8-bit address byte (7-bit target address in bits [7:1], direction in bit 0) and raises a start request. The filter answers one cycle later with exactly one pulse: a grant, which lets the engine drive START and the address, or a deny, which aborts the transaction before anything reaches the bus.

Software controls the filter through a protection lock bit. Once the lock is set, it stays set until reset. While the lock is set, write-direction transactions whose upper address nibble is Ah are refused. This window holds the memory-module serial-presence-detect EEPROMs at address bytes A0h to AEh. Every refusal sets a sticky error bit. Software clears that bit by writing 1 to it. Reads and all other addresses always pass.

Top module: `wpf_filter`

## Requirements
- R1: After reset, grant, deny, lock_state and spd_err are all 0.
- R2: A start_req sampled high at a rising edge makes exactly one of grant or deny high for the single cycle after that edge. With no start_req, both outputs stay low.
- R3: While lock_state is 0, every start request is granted.
- R4: While lock_state is 1, a request whose address bits [7:4] equal 4'hA and whose bit 0 is 0 (write) is denied.
- R5: A request whose address bit 0 is 1 (read) is always granted.
- R6: A request whose address bits [7:4] are not 4'hA is always granted, for both directions.
- R7: A deny sets spd_err at the same edge that raises deny. spd_err stays set afterwards.
- R8: A register write to the error bit (err_wr high) with err_wdata 1 clears spd_err. The same write with err_wdata 0 has no effect.
- R9: If a violation and an error clear happen in the same cycle, spd_err ends up set.
- R10: A lock write with lock_wdata 1 sets lock_state. Later lock writes of 0 do not clear it. A write of 0 while the lock is clear leaves it clear.
- R11: A request in the same cycle as the lock write that sets the lock is judged against the old lock value (0) and is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Engine asks to open a transaction this cycle |
| addr_byte | input | 8 | Address byte: target address [7:1], direction [0] (1 = read) |
| lock_wr | input | 1 | Register write strobe for the lock bit |
| lock_wdata | input | 1 | Value written to the lock bit |
| err_wr | input | 1 | Register write strobe for the error bit |
| err_wdata | input | 1 | Value written to the error bit (1 clears) |
| grant | output | 1 | One-cycle pulse: transaction may proceed |
| deny | output | 1 | One-cycle pulse: transaction aborted |
| lock_state | output | 1 | Current lock bit |
| spd_err | output | 1 | Sticky protected-write error |

## Verification
The latency property assumes start_req is treated as a fresh request in every cycle it is high. It also assumes addr_byte is stable in the cycle the request is sampled. The bench raises start_req for one cycle at a time and drives the address and all strobes at the falling edge, so every sampled value is settled. The error-hold property assumes an error clear happens only through err_wr. The bench holds err_wr low except in its deliberate clear cycles.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  localparam int WPF_ADDR_W = 8;
  localparam int WPF_TAG_W  = 4;

  // Upper nibble of the address byte.
  function automatic logic [WPF_TAG_W-1:0] wpf_tag(input logic [WPF_ADDR_W-1:0] a);
    return a[WPF_ADDR_W-1 -: WPF_TAG_W];
  endfunction

  // Bit 0 low means write direction.
  function automatic logic wpf_is_write(input logic [WPF_ADDR_W-1:0] a);
    return ~a[0];
  endfunction

  // A write aimed at the protected window.
  function automatic logic wpf_protected(input logic [WPF_ADDR_W-1:0] a,
                                         input logic [WPF_TAG_W-1:0]  win);
    return (wpf_tag(a) == win) && wpf_is_write(a);
  endfunction
endpackage

// File: rtl/wpf_window_match.sv
module wpf_window_match
  import wpf_pkg::*;
#(
  parameter logic [WPF_TAG_W-1:0] WIN_TAG = 4'hA
) (
  input  logic [WPF_ADDR_W-1:0] addr_byte,
  output logic                  hit
);
  always_comb hit = wpf_protected(addr_byte, WIN_TAG);
endmodule

// File: rtl/wpf_lock_reg.sv
module wpf_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  output logic lock_q
);
  // Only a 0 -> 1 transition is ever honoured.
  logic set_w;
  assign set_w = wr & wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lock_q <= 1'b0;
    else if (set_w) lock_q <= 1'b1;
  end
endmodule

// File: rtl/wpf_err_sticky.sv
module wpf_err_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic err_q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   err_q <= 1'b0;
    else if (set) err_q <= 1'b1;
    else if (clr) err_q <= 1'b0;
  end
endmodule

// File: rtl/wpf_filter.sv
module wpf_filter
  import wpf_pkg::*;
#(
  parameter logic [WPF_TAG_W-1:0] WIN_TAG = 4'hA
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  input  logic [WPF_ADDR_W-1:0] addr_byte,
  input  logic                  lock_wr,
  input  logic                  lock_wdata,
  input  logic                  err_wr,
  input  logic                  err_wdata,
  output logic                  grant,
  output logic                  deny,
  output logic                  lock_state,
  output logic                  spd_err
);
  // Named internal events, also used by the checker.
  logic win_hit_w;
  logic viol_w;
  logic pass_w;
  logic err_clr_w;

  wpf_window_match #(.WIN_TAG(WIN_TAG)) u_match (
    .addr_byte (addr_byte),
    .hit       (win_hit_w)
  );

  wpf_lock_reg u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (lock_wr),
    .wdata  (lock_wdata),
    .lock_q (lock_state)
  );

  assign viol_w    = start_req & lock_state & win_hit_w;
  assign pass_w    = start_req & ~viol_w;
  assign err_clr_w = err_wr & err_wdata;

  wpf_err_sticky u_err (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (viol_w),
    .clr   (err_clr_w),
    .err_q (spd_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= pass_w;
      deny  <= viol_w;
    end
  end
endmodule

// File: rtl/wpf_filter_chk.sv
module wpf_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic [7:0] addr_byte,
  input logic       err_wr,
  input logic       err_wdata,
  input logic       grant,
  input logic       deny,
  input logic       lock_state,
  input logic       spd_err,
  input logic       viol_w
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && deny));
  // R2
  one_cycle_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((grant || deny) == $past(start_req)));
  // R3
  unlocked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(start_req) && !$past(lock_state)) |-> grant);
  // R4
  violation_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(viol_w)) |-> deny);
  // R5
  read_never_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && deny) |-> !$past(addr_byte[0]));
  // R7
  deny_sets_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    deny |-> spd_err);
  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(spd_err) && !($past(err_wr) && $past(err_wdata))) |-> spd_err);
  // R10
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(lock_state)) |-> lock_state);
endmodule

bind wpf_filter wpf_filter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_req  (start_req),
  .addr_byte  (addr_byte),
  .err_wr     (err_wr),
  .err_wdata  (err_wdata),
  .grant      (grant),
  .deny       (deny),
  .lock_state (lock_state),
  .spd_err    (spd_err),
  .viol_w     (viol_w)
);

// File: tb/sim_wpf_filter.sv
module sim_wpf_filter;
  localparam int CLK_NS = 10;
  localparam int NVEC   = 15;
  // Vector: [9] lock wanted, [8:1] address byte, [0] expected deny.
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 8'hA0, 1'b0}, {1'b0, 8'hA2, 1'b0}, {1'b0, 8'hAE, 1'b0},
    {1'b0, 8'hA1, 1'b0}, {1'b0, 8'h50, 1'b0},
    {1'b1, 8'hA0, 1'b1}, {1'b1, 8'hAE, 1'b1}, {1'b1, 8'hA6, 1'b1},
    {1'b1, 8'hA1, 1'b0}, {1'b1, 8'hAF, 1'b0}, {1'b1, 8'h9E, 1'b0},
    {1'b1, 8'hB0, 1'b0}, {1'b1, 8'h00, 1'b0}, {1'b1, 8'hFE, 1'b0},
    {1'b1, 8'hA8, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic [7:0] addr_byte = 8'h00;
  logic lock_wr = 1'b0, lock_wdata = 1'b0, err_wr = 1'b0, err_wdata = 1'b0;
  logic grant, deny, lock_state, spd_err;
  int n_run = 0, n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  wpf_filter u0 (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .addr_byte(addr_byte),
    .lock_wr(lock_wr), .lock_wdata(lock_wdata), .err_wr(err_wr),
    .err_wdata(err_wdata), .grant(grant), .deny(deny),
    .lock_state(lock_state), .spd_err(spd_err)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_lock(input logic v);
    @(negedge clk);
    lock_wr = 1'b1; lock_wdata = v;
    @(negedge clk);
    lock_wr = 1'b0; lock_wdata = 1'b0;
  endtask

  task automatic write_err(input logic v);
    @(negedge clk);
    err_wr = 1'b1; err_wdata = v;
    @(negedge clk);
    err_wr = 1'b0; err_wdata = 1'b0;
  endtask

  // Issue one request; the outputs are compared one cycle later.
  task automatic request(input logic [7:0] a, input logic exp_deny, input string req);
    @(negedge clk);
    start_req = 1'b1; addr_byte = a;
    @(negedge clk);
    start_req = 1'b0;
    check(req, {2'b00, grant, deny}, {2'b00, ~exp_deny, exp_deny});
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1", {grant, deny, lock_state, spd_err}, 4'b0000);

    // Table walk: R3 when unlocked, R4/R5/R6 when locked
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][9] && !lock_state) write_lock(1'b1);
      request(VEC[i][8:1], VEC[i][0],
              !VEC[i][9] ? "R3" : (VEC[i][0] ? "R4" : (VEC[i][1] ? "R5" : "R6")));
    end
    // R7 error is sticky after the denials
    check("R7", {3'b000, spd_err}, 4'b0001);

    // R2 outputs drop after the pulse and stay low with no request
    @(negedge clk);
    check("R2", {2'b00, grant, deny}, 4'b0000);

    // R8 writing 0 leaves the error; writing 1 clears it
    write_err(1'b0);
    check("R8", {3'b000, spd_err}, 4'b0001);
    write_err(1'b1);
    check("R8", {3'b000, spd_err}, 4'b0000);

    // R9 violation in the same cycle as a clear keeps the error set
    @(negedge clk);
    start_req = 1'b1; addr_byte = 8'hA4; err_wr = 1'b1; err_wdata = 1'b1;
    @(negedge clk);
    start_req = 1'b0; err_wr = 1'b0; err_wdata = 1'b0;
    check("R9", {2'b00, deny, spd_err}, 4'b0011);

    // R10 a later write of 0 does not release the lock
    write_lock(1'b0);
    check("R10", {3'b000, lock_state}, 4'b0001);
    request(8'hA0, 1'b1, "R10");

    // R1 reset clears lock and error
    do_reset();
    check("R1", {grant, deny, lock_state, spd_err}, 4'b0000);

    // R10 writing 0 while clear keeps it clear
    write_lock(1'b0);
    check("R10", {3'b000, lock_state}, 4'b0000);
    request(8'hA0, 1'b0, "R10");

    // R11 request in the lock-setting cycle uses the old lock value
    @(negedge clk);
    start_req = 1'b1; addr_byte = 8'hA0; lock_wr = 1'b1; lock_wdata = 1'b1;
    @(negedge clk);
    start_req = 1'b0; lock_wr = 1'b0; lock_wdata = 1'b0;
    check("R11", {grant, deny, lock_state, spd_err}, 4'b1010);
    request(8'hA0, 1'b1, "R11");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule